// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the hardware part of entering an exception handler on a small 32-bit processor. Each idle cycle it looks at four request lines: a maskable interrupt, a non-maskable interrupt (NMI), a break trap and a bus fault. It gates them with the flags in the condition-code register, accepts the highest-priority one, and latches a snapshot of the core's architectural context (PC, condition codes, stack pointers, vector base and delay-slot amount).

Over the next cycles it works out the values the core must commit. These are the saved return address, the exception status word, the shifted condition-code register and the swapped stack pointers. It then reads the handler address from the vector table through a valid/ready read port. When that word arrives, `done` pulses for one cycle. During that cycle the new PC, the updated registers and their write strobes are valid, and the core commits them.

The condition-code register is not written to memory. Its old flags are pushed by shifting them upward inside the register itself. A return address taken inside a branch delay slot is wound back, so the branch runs again after the handler returns.

Top module: `exc_entry_seq`

## Requirements
- R1: With several requests accepted in the same idle cycle, exactly one entry is made, in the order NMI, bus fault, break, maskable interrupt. `taken_src` reports the winner as 3 for NMI, 2 for bus fault, 1 for break and 0 for interrupt.
- R2: A maskable interrupt is taken only if `irq_req` is high, bit 6 (I) of `cur_ccs` is set and `irq_lock` is low. Otherwise the block stays idle (`busy` low).
- R3: An NMI is taken only if its M flag is set. The M flag is bit 7 of `cur_ccs` when `arch_ver` is below 32, and bit 30 when `arch_ver` is 32 or above.
- R4: The vector is 0 for an NMI, `bf_vec` for a bus fault, `brk_vec` for a break and `irq_vec` for an interrupt. `exs_out` carries the vector in bits 15:8 and zero in every other bit.
- R5: An NMI saves the return address in `nrp_out` with `nrp_we` high. Every other source saves it in `erp_out` with `erp_we` high. Exactly one of the two strobes is high during `done`.
- R6: The saved return address is `cur_pc - dslot_amt`. `dslot_clr` is high during `done` exactly when `dslot_amt` was nonzero.
- R7: If bit 8 (U) of `cur_ccs` was set, `usp_out` equals the old `cur_sp`, `usp_we` is high and `sp_out` equals `kern_sp`. If U was clear, `sp_out` equals `cur_sp` and `usp_we` is low.
- R8: `ccs_out` keeps bits 31:30, takes old bits 19:0 into bits 29:10 and has bits 9:0 at zero. For an NMI, the M flag is cleared before this shift.
- R9: The vector read uses address `vbase + 4*vector`. `rd_valid` and `rd_addr` hold steady until `rd_ready`, and `new_pc` equals the `rd_data` returned.
- R10: `done` is a single-cycle pulse in the cycle after the read handshake. Requests that arrive while `busy` is high are dropped, and no further entry follows.
- R11: A bus-fault request seen while a bus-fault entry is in progress sets `double_fault`. The flag stays set until reset, and no new entry is started for it.
- R12: After reset, `busy`, `done`, `rd_valid`, `double_fault` and all write strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 1 | Maskable interrupt request |
| irq_vec | input | 8 | Vector from the interrupt controller |
| irq_lock | input | 1 | Interrupt lock, blocks maskable interrupts |
| nmi_req | input | 1 | Non-maskable interrupt request |
| brk_req | input | 1 | Break trap request |
| brk_vec | input | 8 | Programmed trap vector |
| bf_req | input | 1 | Bus fault request |
| bf_vec | input | 8 | Vector from the MMU for the fault |
| arch_ver | input | 8 | Architecture version, selects M flag position |
| cur_pc | input | 32 | Current PC |
| cur_ccs | input | 32 | Current condition-code register |
| cur_sp | input | 32 | Current stack pointer |
| kern_sp | input | 32 | Kernel stack pointer |
| vbase | input | 32 | Exception vector table base |
| dslot_amt | input | 2 | Delay-slot amount, 0 when not in a slot |
| rd_valid | output | 1 | Vector read request |
| rd_addr | output | 32 | Vector read address |
| rd_ready | input | 1 | Read data returned |
| rd_data | input | 32 | Read data |
| busy | output | 1 | An entry is in progress |
| done | output | 1 | One-cycle pulse; results valid |
| taken_src | output | 2 | Source taken (3 NMI, 2 fault, 1 break, 0 irq) |
| new_pc | output | 32 | Handler address |
| erp_out | output | 32 | Exception return address |
| erp_we | output | 1 | Write strobe for erp_out |
| nrp_out | output | 32 | NMI return address |
| nrp_we | output | 1 | Write strobe for nrp_out |
| exs_out | output | 32 | Exception status word |
| ccs_out | output | 32 | Shifted condition-code register |
| sp_out | output | 32 | New stack pointer |
| usp_out | output | 32 | Saved user stack pointer |
| usp_we | output | 1 | Write strobe for usp_out |
| dslot_clr | output | 1 | Clear delay-slot state |
| double_fault | output | 1 | Sticky nested bus-fault error |

## Verification
The assertions rely on two things at the boundary. First, `rd_ready` is driven high only while `rd_valid` is high. Second, the context inputs matter only in the cycle a request is accepted. The bench respects both. Its responder raises `rd_ready` only after it has seen `rd_valid`, and it changes context and request lines only at negative edges.

Apart from the deliberate double-fault case, every new request is raised while the block is idle. Nested requests are raised only to show that they are dropped. Random rounds draw flag words, versions, locks, delay-slot amounts and read latencies, so the acceptance gates are exercised both open and closed.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
   // Source code values also appear on the taken_src port.
   typedef enum logic [1:0] {
      SRC_IRQ  = 2'd0,
      SRC_BRK  = 2'd1,
      SRC_BFLT = 2'd2,
      SRC_NMI  = 2'd3
   } exc_src_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SAVE  = 2'd1,
      ST_FETCH = 2'd2,
      ST_DONE  = 2'd3
   } seq_state_e;

   localparam int NUM_SRC = 4;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_entry_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int VW        = 8,
   parameter int VER_W     = 8,
   parameter int I_BIT     = 6,
   parameter int M_BIT_OLD = 7,
   parameter int M_BIT_NEW = 30,
   parameter int VER_SPLIT = 32,
   parameter int M_LAYOUT  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             irq_req,
   input  logic             irq_lock,
   input  logic             nmi_req,
   input  logic             brk_req,
   input  logic             bf_req,
   input  logic [XLEN-1:0]  ccs,
   input  logic [VER_W-1:0] arch_ver,
   input  logic [VW-1:0]    irq_vec,
   input  logic [VW-1:0]    brk_vec,
   input  logic [VW-1:0]    bf_vec,
   output logic             take,
   output exc_src_e         src,
   output logic [VW-1:0]    vec,
   output logic [XLEN-1:0]  m_mask
);
   localparam logic [XLEN-1:0] OLD_MASK = XLEN'(1) << M_BIT_OLD;
   localparam logic [XLEN-1:0] NEW_MASK = XLEN'(1) << M_BIT_NEW;

   logic [NUM_SRC-1:0] grant;
   logic               m_ok;
   logic               irq_ok;

   // M_LAYOUT: 0 picks the flag position from arch_ver, 1 fixes the old one, 2 the new one.
   generate
      if (M_LAYOUT == 0) begin : g_m_runtime
         assign m_mask = (arch_ver < VER_W'(VER_SPLIT)) ? OLD_MASK : NEW_MASK;
      end else if (M_LAYOUT == 1) begin : g_m_old
         assign m_mask = OLD_MASK;
      end else begin : g_m_new
         assign m_mask = NEW_MASK;
      end
   endgenerate

   always_comb begin
      m_ok   = |(ccs & m_mask);
      irq_ok = irq_req & ccs[I_BIT] & ~irq_lock;
      grant  = '0;
      if (enable) begin
         if (nmi_req && m_ok)   grant[SRC_NMI]  = 1'b1;
         else if (bf_req)       grant[SRC_BFLT] = 1'b1;
         else if (brk_req)      grant[SRC_BRK]  = 1'b1;
         else if (irq_ok)       grant[SRC_IRQ]  = 1'b1;
      end
   end

   always_comb begin
      take = |grant;
      src  = SRC_IRQ;
      vec  = irq_vec;
      if (grant[SRC_NMI]) begin
         src = SRC_NMI;
         vec = '0;
      end else if (grant[SRC_BFLT]) begin
         src = SRC_BFLT;
         vec = bf_vec;
      end else if (grant[SRC_BRK]) begin
         src = SRC_BRK;
         vec = brk_vec;
      end
   end

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R1
   AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      grant[SRC_IRQ] |-> (irq_req && ccs[I_BIT] && !irq_lock)); // R2
   AST_NMI_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      grant[SRC_NMI] |-> ((ccs & m_mask) != '0)); // R3
endmodule

// File: rtl/exc_ctx_update.sv
module exc_ctx_update
   import exc_entry_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int VW        = 8,
   parameter int DSW       = 2,
   parameter int U_BIT     = 8,
   parameter int EXS_LSB   = 8,
   parameter int CCS_KEEP  = 2,
   parameter int CCS_SHIFT = 10
) (
   input  exc_src_e        src,
   input  logic [VW-1:0]   vec,
   input  logic [XLEN-1:0] pc,
   input  logic [XLEN-1:0] ccs,
   input  logic [XLEN-1:0] sp,
   input  logic [XLEN-1:0] ksp,
   input  logic [DSW-1:0]  ds,
   input  logic [XLEN-1:0] m_mask,
   output logic [XLEN-1:0] ret_addr,
   output logic            is_nmi,
   output logic [XLEN-1:0] exs,
   output logic [XLEN-1:0] ccs_new,
   output logic [XLEN-1:0] sp_new,
   output logic [XLEN-1:0] usp_new,
   output logic            swap,
   output logic            ds_hit
);
   localparam logic [XLEN-1:0] KEEP_MASK = ~({XLEN{1'b1}} >> CCS_KEEP);

   logic [XLEN-1:0] ccs_m;

   always_comb begin
      is_nmi   = (src == SRC_NMI);
      ccs_m    = is_nmi ? (ccs & ~m_mask) : ccs;
      // Top bits stay put; the rest moves up by CCS_SHIFT and the low bits fill with zero.
      ccs_new  = (ccs_m & KEEP_MASK) |
                 ((ccs_m << (CCS_SHIFT + CCS_KEEP)) >> CCS_KEEP);
      exs      = XLEN'(vec) << EXS_LSB;
      ret_addr = pc - XLEN'(ds);
      ds_hit   = (ds != '0);
      swap     = ccs[U_BIT];
      sp_new   = swap ? ksp : sp;
      usp_new  = sp;
   end
endmodule

// File: rtl/exc_vec_fetch.sv
module exc_vec_fetch #(
   parameter int XLEN = 32,
   parameter int VW   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [XLEN-1:0] base,
   input  logic [VW-1:0]   vec,
   output logic            rd_valid,
   output logic [XLEN-1:0] rd_addr,
   input  logic            rd_ready,
   input  logic [XLEN-1:0] rd_data,
   output logic            fetched,
   output logic [XLEN-1:0] pc_new
);
   localparam int WORD_SH = 2;

   logic            act_q;
   logic [XLEN-1:0] addr_q;
   logic [XLEN-1:0] pc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         addr_q <= '0;
         pc_q   <= '0;
      end else if (start) begin
         act_q  <= 1'b1;
         addr_q <= base + (XLEN'(vec) << WORD_SH);
      end else if (act_q && rd_ready) begin
         act_q  <= 1'b0;
         pc_q   <= rd_data;
      end
   end

   assign rd_valid = act_q;
   assign rd_addr  = addr_q;
   assign fetched  = act_q & rd_ready;
   assign pc_new   = pc_q;

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr))); // R9
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_entry_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int VW        = 8,
   parameter int VER_W     = 8,
   parameter int DSW       = 2,
   parameter int I_BIT     = 6,
   parameter int U_BIT     = 8,
   parameter int M_BIT_OLD = 7,
   parameter int M_BIT_NEW = 30,
   parameter int VER_SPLIT = 32,
   parameter int EXS_LSB   = 8,
   parameter int CCS_KEEP  = 2,
   parameter int CCS_SHIFT = 10,
   parameter int M_LAYOUT  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_req,
   input  logic [VW-1:0]    irq_vec,
   input  logic             irq_lock,
   input  logic             nmi_req,
   input  logic             brk_req,
   input  logic [VW-1:0]    brk_vec,
   input  logic             bf_req,
   input  logic [VW-1:0]    bf_vec,
   input  logic [VER_W-1:0] arch_ver,
   input  logic [XLEN-1:0]  cur_pc,
   input  logic [XLEN-1:0]  cur_ccs,
   input  logic [XLEN-1:0]  cur_sp,
   input  logic [XLEN-1:0]  kern_sp,
   input  logic [XLEN-1:0]  vbase,
   input  logic [DSW-1:0]   dslot_amt,
   output logic             rd_valid,
   output logic [XLEN-1:0]  rd_addr,
   input  logic             rd_ready,
   input  logic [XLEN-1:0]  rd_data,
   output logic             busy,
   output logic             done,
   output logic [1:0]       taken_src,
   output logic [XLEN-1:0]  new_pc,
   output logic [XLEN-1:0]  erp_out,
   output logic             erp_we,
   output logic [XLEN-1:0]  nrp_out,
   output logic             nrp_we,
   output logic [XLEN-1:0]  exs_out,
   output logic [XLEN-1:0]  ccs_out,
   output logic [XLEN-1:0]  sp_out,
   output logic [XLEN-1:0]  usp_out,
   output logic             usp_we,
   output logic             dslot_clr,
   output logic             double_fault
);
   localparam logic [XLEN-1:0] EXS_FIELD = ((XLEN'(1) << VW) - XLEN'(1)) << EXS_LSB;
   localparam logic [XLEN-1:0] LOW_MASK  = (XLEN'(1) << CCS_SHIFT) - XLEN'(1);

   // Elaboration-time parameter checks.
   generate
      if (CCS_KEEP + CCS_SHIFT >= XLEN) begin : g_bad_shift
         $error("condition-code shift leaves no moved bits");
      end
      if (U_BIT >= CCS_SHIFT) begin : g_bad_ubit
         $error("user flag must lie in the bits cleared by the shift");
      end
      if (EXS_LSB + VW > XLEN) begin : g_bad_exs
         $error("vector field does not fit the status word");
      end
      if (I_BIT >= XLEN || M_BIT_OLD >= XLEN || M_BIT_NEW >= XLEN) begin : g_bad_flag
         $error("flag position outside the condition-code word");
      end
      if (DSW < 1 || DSW >= XLEN) begin : g_bad_dsw
         $error("delay-slot width out of range");
      end
      if (M_LAYOUT < 0 || M_LAYOUT > 2) begin : g_bad_layout
         $error("unknown M flag layout option");
      end
   endgenerate

   seq_state_e      state_q;
   exc_src_e        src_q;
   logic [VW-1:0]   vec_q;
   logic [XLEN-1:0] pc_q, ccs_q, sp_q, ksp_q, base_q, mmask_q;
   logic [DSW-1:0]  ds_q;

   logic            arb_take;
   exc_src_e        arb_src;
   logic [VW-1:0]   arb_vec;
   logic [XLEN-1:0] arb_mmask;

   logic [XLEN-1:0] c_ret, c_exs, c_ccs, c_sp, c_usp;
   logic            c_nmi, c_swap, c_ds;

   logic [XLEN-1:0] ret_r, exs_r, ccs_r, sp_r, usp_r;
   logic            nmi_r, swap_r, ds_r, df_q;
   logic            fetch_start, fetched;

   exc_arbiter #(
      .XLEN(XLEN), .VW(VW), .VER_W(VER_W), .I_BIT(I_BIT),
      .M_BIT_OLD(M_BIT_OLD), .M_BIT_NEW(M_BIT_NEW),
      .VER_SPLIT(VER_SPLIT), .M_LAYOUT(M_LAYOUT)
   ) i_arb (
      .clk(clk), .rst_n(rst_n), .enable(state_q == ST_IDLE),
      .irq_req(irq_req), .irq_lock(irq_lock), .nmi_req(nmi_req),
      .brk_req(brk_req), .bf_req(bf_req), .ccs(cur_ccs), .arch_ver(arch_ver),
      .irq_vec(irq_vec), .brk_vec(brk_vec), .bf_vec(bf_vec),
      .take(arb_take), .src(arb_src), .vec(arb_vec), .m_mask(arb_mmask)
   );

   exc_ctx_update #(
      .XLEN(XLEN), .VW(VW), .DSW(DSW), .U_BIT(U_BIT), .EXS_LSB(EXS_LSB),
      .CCS_KEEP(CCS_KEEP), .CCS_SHIFT(CCS_SHIFT)
   ) i_ctx (
      .src(src_q), .vec(vec_q), .pc(pc_q), .ccs(ccs_q), .sp(sp_q), .ksp(ksp_q),
      .ds(ds_q), .m_mask(mmask_q), .ret_addr(c_ret), .is_nmi(c_nmi),
      .exs(c_exs), .ccs_new(c_ccs), .sp_new(c_sp), .usp_new(c_usp),
      .swap(c_swap), .ds_hit(c_ds)
   );

   assign fetch_start = (state_q == ST_SAVE);

   exc_vec_fetch #(.XLEN(XLEN), .VW(VW)) i_fetch (
      .clk(clk), .rst_n(rst_n), .start(fetch_start), .base(base_q), .vec(vec_q),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
      .rd_data(rd_data), .fetched(fetched), .pc_new(new_pc)
   );

   // Sequencer and context snapshot.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         src_q   <= SRC_IRQ;
         vec_q   <= '0;
         pc_q    <= '0;
         ccs_q   <= '0;
         sp_q    <= '0;
         ksp_q   <= '0;
         base_q  <= '0;
         mmask_q <= '0;
         ds_q    <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (arb_take) begin
               state_q <= ST_SAVE;
               src_q   <= arb_src;
               vec_q   <= arb_vec;
               pc_q    <= cur_pc;
               ccs_q   <= cur_ccs;
               sp_q    <= cur_sp;
               ksp_q   <= kern_sp;
               base_q  <= vbase;
               mmask_q <= arb_mmask;
               ds_q    <= dslot_amt;
            end
            ST_SAVE:  state_q <= ST_FETCH;
            ST_FETCH: if (fetched) state_q <= ST_DONE;
            ST_DONE:  state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   // Result registers, loaded once per entry.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ret_r  <= '0;
         exs_r  <= '0;
         ccs_r  <= '0;
         sp_r   <= '0;
         usp_r  <= '0;
         nmi_r  <= 1'b0;
         swap_r <= 1'b0;
         ds_r   <= 1'b0;
      end else if (state_q == ST_SAVE) begin
         ret_r  <= c_ret;
         exs_r  <= c_exs;
         ccs_r  <= c_ccs;
         sp_r   <= c_sp;
         usp_r  <= c_usp;
         nmi_r  <= c_nmi;
         swap_r <= c_swap;
         ds_r   <= c_ds;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) df_q <= 1'b0;
      else if (bf_req && (state_q != ST_IDLE) && (src_q == SRC_BFLT)) df_q <= 1'b1;
   end

   assign busy         = (state_q != ST_IDLE);
   assign done         = (state_q == ST_DONE);
   assign taken_src    = src_q;
   assign erp_out      = ret_r;
   assign nrp_out      = ret_r;
   assign erp_we       = done & ~nmi_r;
   assign nrp_we       = done & nmi_r;
   assign exs_out      = exs_r;
   assign ccs_out      = ccs_r;
   assign sp_out       = sp_r;
   assign usp_out      = usp_r;
   assign usp_we       = done & swap_r;
   assign dslot_clr    = done & ds_r;
   assign double_fault = df_q;

   AST_CCS_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((ccs_out & LOW_MASK) == '0)); // R8
   AST_EXS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((exs_out & ~EXS_FIELD) == '0)); // R4
   AST_ONE_RET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (erp_we ^ nrp_we)); // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_DF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      double_fault |=> double_fault); // R11
   AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> !(erp_we || nrp_we || usp_we || dslot_clr)); // R12
endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 0, irq_lock = 0, nmi_req = 0, brk_req = 0, bf_req = 0;
   logic [7:0]  irq_vec = 0, brk_vec = 0, bf_vec = 0, arch_ver = 0;
   logic [31:0] cur_pc = 0, cur_ccs = 0, cur_sp = 0, kern_sp = 0, vbase = 0;
   logic [1:0]  dslot_amt = 0;
   logic        rd_ready = 0;
   logic [31:0] rd_data = 0;
   logic        rd_valid, busy, done, erp_we, nrp_we, usp_we, dslot_clr, double_fault;
   logic [31:0] rd_addr, new_pc, erp_out, nrp_out, exs_out, ccs_out, sp_out, usp_out;
   logic [1:0]  taken_src;

   int checks = 0, fails = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   exc_entry_seq i_exc_entry_seq (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
      .irq_lock(irq_lock), .nmi_req(nmi_req), .brk_req(brk_req), .brk_vec(brk_vec),
      .bf_req(bf_req), .bf_vec(bf_vec), .arch_ver(arch_ver), .cur_pc(cur_pc),
      .cur_ccs(cur_ccs), .cur_sp(cur_sp), .kern_sp(kern_sp), .vbase(vbase),
      .dslot_amt(dslot_amt), .rd_valid(rd_valid), .rd_addr(rd_addr),
      .rd_ready(rd_ready), .rd_data(rd_data), .busy(busy), .done(done),
      .taken_src(taken_src), .new_pc(new_pc), .erp_out(erp_out), .erp_we(erp_we),
      .nrp_out(nrp_out), .nrp_we(nrp_we), .exs_out(exs_out), .ccs_out(ccs_out),
      .sp_out(sp_out), .usp_out(usp_out), .usp_we(usp_we), .dslot_clr(dslot_clr),
      .double_fault(double_fault)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit m_flag(input logic [31:0] c, input logic [7:0] v);
      return (v < 8'd32) ? c[7] : c[30];
   endfunction

   // Expected winner: 3 NMI, 2 fault, 1 break, 0 irq, -1 none.
   function automatic int pick(input bit ir, input bit nm, input bit bk, input bit bf,
                               input logic [31:0] c, input logic [7:0] v, input bit lk);
      if (nm && m_flag(c, v)) return 3;
      if (bf) return 2;
      if (bk) return 1;
      if (ir && c[6] && !lk) return 0;
      return -1;
   endfunction

   function automatic logic [31:0] exp_ccs(input logic [31:0] c, input int s,
                                           input logic [7:0] v);
      logic [31:0] m;
      m = c;
      if (s == 3) begin
         if (v < 8'd32) m[7] = 1'b0;
         else m[30] = 1'b0;
      end
      return {m[31:30], m[19:0], 10'b0};
   endfunction

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
   endfunction

   task automatic run_entry(input bit ir, input bit nm, input bit bk, input bit bf,
                            input logic [7:0] iv, input logic [7:0] bv, input logic [7:0] fv,
                            input logic [31:0] pc, input logic [31:0] c,
                            input logic [31:0] sp, input logic [31:0] ks,
                            input logic [31:0] base, input logic [1:0] ds,
                            input logic [7:0] ver, input bit lk, input int lat,
                            input bit poke, input bit poke_bf);
      int s;
      logic [7:0] v;
      logic [31:0] a;
      s = pick(ir, nm, bk, bf, c, ver, lk);
      @(negedge clk);
      irq_req = ir; nmi_req = nm; brk_req = bk; bf_req = bf;
      irq_vec = iv; brk_vec = bv; bf_vec = fv; cur_pc = pc; cur_ccs = c;
      cur_sp = sp; kern_sp = ks; vbase = base; dslot_amt = ds; arch_ver = ver;
      irq_lock = lk;
      @(negedge clk);
      irq_req = 0; nmi_req = 0; brk_req = 0; bf_req = 0;
      if (s < 0) begin
         chk(busy == 1'b0, "R2/R3 gated request ignored", 32'(busy), 32'd0);
         return;
      end
      chk(busy == 1'b1, "R1 request accepted", 32'(busy), 32'd1);
      v = (s == 3) ? 8'd0 : (s == 2) ? fv : (s == 1) ? bv : iv;
      for (int g = 0; g < 8 && !rd_valid; g++) begin
         if (poke) begin nmi_req = 1; brk_req = 1; cur_ccs = 32'hFFFF_FFFF; end
         if (poke_bf) bf_req = 1;
         @(negedge clk);
         nmi_req = 0; brk_req = 0; bf_req = 0;
      end
      a = base + {22'd0, v, 2'b00};
      chk(rd_valid === 1'b1 && rd_addr === a, "R9 read address", rd_addr, a);
      for (int k = 0; k < lat; k++) begin
         @(negedge clk);
         chk(rd_valid === 1'b1 && rd_addr === a, "R9 request held", rd_addr, a);
      end
      rd_ready = 1; rd_data = mem_word(rd_addr);
      @(negedge clk);
      rd_ready = 0;
      chk(done === 1'b1, "R10 done after handshake", 32'(done), 32'd1);
      chk(taken_src === 2'(s), "R1 source chosen", 32'(taken_src), 32'(s));
      chk(new_pc === mem_word(a), "R9 handler address", new_pc, mem_word(a));
      chk(exs_out === {16'd0, v, 8'd0}, "R4 status word", exs_out, {16'd0, v, 8'd0});
      chk(ccs_out === exp_ccs(c, s, ver), "R8 flag shift", ccs_out, exp_ccs(c, s, ver));
      if (s == 3) begin
         chk(nrp_we && !erp_we && nrp_out === pc - 32'(ds), "R5 R6 NMI return",
             nrp_out, pc - 32'(ds));
      end else begin
         chk(erp_we && !nrp_we && erp_out === pc - 32'(ds), "R5 R6 return",
             erp_out, pc - 32'(ds));
      end
      chk(dslot_clr === (ds != 0), "R6 slot clear", 32'(dslot_clr), 32'(ds != 0));
      if (c[8]) begin
         chk(usp_we && usp_out === sp && sp_out === ks, "R7 stack swap", sp_out, ks);
      end else begin
         chk(!usp_we && sp_out === sp, "R7 no swap", sp_out, sp);
      end
      @(negedge clk);
      chk(done === 1'b0, "R10 single pulse", 32'(done), 32'd0);
      chk(busy === 1'b0, "R10 nested requests dropped", 32'(busy), 32'd0);
   endtask

   initial begin
      int unsigned seed;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !rd_valid && !double_fault && !erp_we && !nrp_we &&
          !usp_we && !dslot_clr, "R12 reset state", 32'(busy), 32'd0);
      rst_n = 1;
      @(negedge clk);
      chk(busy === 1'b0, "R12 idle after reset", 32'(busy), 32'd0);

      // Directed: all four at once, NMI wins (old layout M at bit 7).
      run_entry(1, 1, 1, 1, 8'h11, 8'h22, 8'h33, 32'h1000, 32'hC000_01C0, 32'h8000,
                32'h9000, 32'h4000, 2'd0, 8'd10, 0, 1, 0, 0);
      // NMI masked in new layout (bit 30 clear) even though bit 7 set: fault wins.
      run_entry(0, 1, 0, 1, 8'h00, 8'h00, 8'h44, 32'h2000, 32'h0000_0080, 32'h1,
                32'h2, 32'h100, 2'd2, 8'd40, 0, 0, 0, 0);
      // NMI in new layout, user mode, delay slot.
      run_entry(0, 1, 0, 0, 8'h00, 8'h00, 8'h00, 32'h3000, 32'h4008_0100, 32'hAAA0,
                32'hBBB0, 32'h200, 2'd1, 8'd32, 0, 2, 1, 0);
      // Break beats irq.
      run_entry(1, 0, 1, 0, 8'h05, 8'hFF, 8'h00, 32'h4444, 32'h0000_0040, 32'h10,
                32'h20, 32'hFFFF_FC00, 2'd3, 8'd0, 0, 0, 0, 0);
      // Irq blocked by lock, then by clear I flag, then taken.
      run_entry(1, 0, 0, 0, 8'h07, 0, 0, 32'h50, 32'h40, 32'h1, 32'h2, 32'h0, 2'd0,
                8'd0, 1, 0, 0, 0);
      run_entry(1, 0, 0, 0, 8'h07, 0, 0, 32'h50, 32'h0, 32'h1, 32'h2, 32'h0, 2'd0,
                8'd0, 0, 0, 0, 0);
      run_entry(1, 0, 0, 0, 8'h07, 0, 0, 32'h50, 32'hFFFF_FF7F, 32'h1, 32'h2, 32'h0,
                2'd0, 8'd0, 0, 1, 0, 0);
      // NMI with old-layout M clear is dropped.
      run_entry(0, 1, 0, 0, 0, 0, 0, 32'h60, 32'h4000_0000, 32'h1, 32'h2, 32'h0, 2'd0,
                8'd31, 0, 0, 0, 0);

      seed = 32'd20240611;
      void'($urandom(seed));
      for (int i = 0; i < 60; i++) begin
         run_entry($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                   $urandom_range(0, 1), 8'($urandom), 8'($urandom), 8'($urandom),
                   $urandom, $urandom, $urandom, $urandom, $urandom,
                   2'($urandom_range(0, 3)), 8'($urandom_range(0, 63)),
                   $urandom_range(0, 1), $urandom_range(0, 4), $urandom_range(0, 1), 0);
      end
      chk(double_fault === 1'b0, "R11 no error without nesting", 32'(double_fault), 32'd0);

      // Nested bus fault during a fault entry.
      run_entry(0, 0, 0, 1, 0, 0, 8'h09, 32'h700, 32'h0, 32'h1, 32'h2, 32'h80, 2'd0,
                8'd0, 0, 1, 0, 1);
      chk(double_fault === 1'b1, "R11 double fault set", 32'(double_fault), 32'd1);
      run_entry(0, 0, 1, 0, 0, 8'h01, 0, 32'h800, 32'h0, 32'h1, 32'h2, 32'h0, 2'd0,
                8'd0, 0, 0, 0, 0);
      chk(double_fault === 1'b1, "R11 double fault sticky", 32'(double_fault), 32'd1);

      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule